// File: doc/BRIEF.md
# Processor Bus Cycle Front End

This block sits next to a 16-bit processor whose address and data share one multiplexed bus and which reports what each bus cycle is for through a 4-bit status code. On each falling edge of the address strobe it captures the address and the boot-space select. In the same clock it turns the status code into a one-hot cycle-type vector, and it raises an error flag when the code matches no known cycle type.

From the captured state and the read and write strobes it drives active-low chip selects for a boot region. ROM sits below address 0x8000 and RAM at 0x8000 and above. It also drives the enable and direction of the bidirectional data buffer that sits between the processor and the backplane. All inputs are sampled on the block clock. The processor's strobes are taken to be already synchronous to that clock.

Top module: `bus_cycle_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, the captured address is 0, the cycle-type vector is 0, the error flag is 0, both chip selects are 1 (inactive) and the buffer enable is 1 (off).
- R2: An address-strobe fall is a clock edge at which the strobe is sampled 0 after being sampled 1 at the edge before. At that edge the captured address takes the bus value. The captured address then holds until the next fall, whatever the bus does in between.
- R3: At the same edge the cycle-type vector takes the decoded status, with one bit set per code. Bit 0 is 1010 (reset), bit 1 is 1101 (status-register update), bit 2 is 0101 (interrupt vector fetch), bit 3 is 1001 (internal ALU or macrostore), bit 4 is 1100 (workspace-pointer update), bit 5 is 0110 (workspace transfer), bit 6 is 0011 (instruction acquisition), bit 7 is 0010 (immediate operand fetch) and bit 8 is 1110 (macroinstruction detect). The vector holds until the next fall.
- R4: At a fall, any other status code (0000, 0001, 0100, 0111, 1000, 1011, 1111) sets the vector to all zeros and the error flag to 1. A known code clears the error flag.
- R5: The ROM select is 0 while the captured boot select is 1, the captured address is below 0x8000, and the read or write strobe is 0.
- R6: The RAM select is 0 while the captured boot select is 1, the captured address is 0x8000 or above, and the read or write strobe is 0.
- R7: Neither select is active while the captured boot select is 0. The two selects are never active together.
- R8: The buffer enable goes to 0 at an address-strobe fall and stays 0 until the edge that samples the end of a read or write strobe; after that edge it is 1 (bus high-impedance). A cycle with no strobe keeps the buffer enabled.
- R9: The buffer direction is 1 (toward the processor) only while the buffer is enabled and the read strobe is 0. Otherwise it is 0 (toward the bus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| alatch | input | 1 | Address strobe from the processor, high at cycle start |
| rd_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| bstat | input | 4 | Bus status code |
| ad | input | 16 | Multiplexed address/data bus, bit 0 least significant |
| boot_sel | input | 1 | Boot memory space select, high selects the boot region |
| lat_addr | output | 16 | Captured address |
| rom_sel_n | output | 1 | Boot ROM select, active low |
| ram_sel_n | output | 1 | Boot RAM select, active low |
| buf_dir | output | 1 | Data buffer direction, 1 = toward processor |
| buf_oe_n | output | 1 | Data buffer enable, active low |
| cycle_type | output | 9 | One-hot cycle type |
| illegal_status | output | 1 | Unknown status code seen at the last fall |

## Verification
Bad capture state shows on the clock edge after the strobe fall. That edge exposes it as a wrong captured address or cycle-type bit, or as an address or type that drifts while the bus carries data or a new status. A wrong captured boot select or address bit shows combinationally as soon as a strobe drops, as the wrong select or a select under a low boot select. A stuck buffer-window register shows one edge after a strobe ends, as a buffer still driving or one off too early. That is the stuck-enable failure that blocks reads.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int STAT_W = 4;
    localparam int CT_N   = 9;

    typedef enum logic [STAT_W-1:0] {
        ST_RESET  = 4'b1010,
        ST_STUPD  = 4'b1101,
        ST_VECTOR = 4'b0101,
        ST_ALU    = 4'b1001,
        ST_WPUPD  = 4'b1100,
        ST_WSXFER = 4'b0110,
        ST_IFETCH = 4'b0011,
        ST_IMMOP  = 4'b0010,
        ST_MACRO  = 4'b1110
    } bus_stat_e;

    typedef struct packed {
        logic [CT_N-1:0] kind;
        logic            bad;
    } cyc_info_t;

    function automatic cyc_info_t decode_status(logic [STAT_W-1:0] s);
        cyc_info_t r;
        r.kind = '0;
        r.bad  = 1'b0;
        case (s)
            ST_RESET:  r.kind[0] = 1'b1;
            ST_STUPD:  r.kind[1] = 1'b1;
            ST_VECTOR: r.kind[2] = 1'b1;
            ST_ALU:    r.kind[3] = 1'b1;
            ST_WPUPD:  r.kind[4] = 1'b1;
            ST_WSXFER: r.kind[5] = 1'b1;
            ST_IFETCH: r.kind[6] = 1'b1;
            ST_IMMOP:  r.kind[7] = 1'b1;
            ST_MACRO:  r.kind[8] = 1'b1;
            default:   r.bad     = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bsd_addr_latch.sv
module bsd_addr_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alatch,
    input  logic [ADDR_W-1:0] ad,
    input  logic              boot_sel,
    output logic              fall,
    output logic [ADDR_W-1:0] addr_q,
    output logic              boot_q
);
    logic alatch_q;

    assign fall = alatch_q & ~alatch;

    always_ff @(posedge clk) begin
        if (rst) begin
            alatch_q <= 1'b0;
            addr_q   <= '0;
            boot_q   <= 1'b0;
        end else begin
            alatch_q <= alatch;
            if (fall) begin
                addr_q <= ad;
                boot_q <= boot_sel;
            end
        end
    end
endmodule

// File: rtl/bsd_status_decode.sv
module bsd_status_decode
    import bsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic [STAT_W-1:0] bstat,
    output cyc_info_t         info_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            info_q <= '0;
        end else if (fall) begin
            info_q <= decode_status(bstat);
        end
    end
endmodule

// File: rtl/bsd_bus_ctrl.sv
module bsd_bus_ctrl #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RAM_BASE = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              rd_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              boot_q,
    output logic              rom_sel_n,
    output logic              ram_sel_n,
    output logic              buf_dir,
    output logic              buf_oe_n
);
    logic strobe;
    logic strobe_q;
    logic open_q;
    logic in_ram;

    assign strobe = ~rd_n | ~we_n;
    assign in_ram = (addr_q >= RAM_BASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            open_q   <= 1'b0;
        end else begin
            strobe_q <= strobe;
            if (fall) begin
                open_q <= 1'b1;
            end else if (strobe_q && !strobe) begin
                open_q <= 1'b0;
            end
        end
    end

    assign rom_sel_n = ~(boot_q & strobe & ~in_ram);
    assign ram_sel_n = ~(boot_q & strobe & in_ram);
    assign buf_oe_n  = ~open_q;
    assign buf_dir   = open_q & ~rd_n;
endmodule

// File: rtl/bus_cycle_decoder.sv
module bus_cycle_decoder
    import bsd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] RAM_BASE = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alatch,
    input  logic              rd_n,
    input  logic              we_n,
    input  logic [STAT_W-1:0] bstat,
    input  logic [ADDR_W-1:0] ad,
    input  logic              boot_sel,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              rom_sel_n,
    output logic              ram_sel_n,
    output logic              buf_dir,
    output logic              buf_oe_n,
    output logic [CT_N-1:0]   cycle_type,
    output logic              illegal_status
);
    logic      fall;
    logic      boot_q;
    cyc_info_t info_q;

    bsd_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst(rst), .alatch(alatch), .ad(ad), .boot_sel(boot_sel),
        .fall(fall), .addr_q(lat_addr), .boot_q(boot_q)
    );

    bsd_status_decode u_dec (
        .clk(clk), .rst(rst), .fall(fall), .bstat(bstat), .info_q(info_q)
    );

    bsd_bus_ctrl #(.ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE)) u_ctrl (
        .clk(clk), .rst(rst), .fall(fall), .rd_n(rd_n), .we_n(we_n),
        .addr_q(lat_addr), .boot_q(boot_q),
        .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n),
        .buf_dir(buf_dir), .buf_oe_n(buf_oe_n)
    );

    assign cycle_type     = info_q.kind;
    assign illegal_status = info_q.bad;
endmodule

// File: rtl/bus_cycle_decoder_chk.sv
module bus_cycle_decoder_chk #(
    parameter int ADDR_W = 16,
    parameter int CT_N   = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              alatch,
    input logic [ADDR_W-1:0] ad,
    input logic [ADDR_W-1:0] lat_addr,
    input logic              boot_q,
    input logic              rom_sel_n,
    input logic              ram_sel_n,
    input logic              buf_dir,
    input logic              buf_oe_n,
    input logic [CT_N-1:0]   cycle_type,
    input logic              illegal_status
);
    logic al_prev;
    always_ff @(posedge clk) begin
        if (rst) al_prev <= 1'b0;
        else     al_prev <= alatch;
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (al_prev && !alatch) |=> (lat_addr == $past(ad)));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !(al_prev && !alatch) |=> $stable(lat_addr));

    a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cycle_type));

    a_r4_bad_empty: assert property (@(posedge clk) disable iff (rst)
        illegal_status |-> (cycle_type == '0));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!rom_sel_n && !ram_sel_n));

    a_r7_boot_gate: assert property (@(posedge clk) disable iff (rst)
        !boot_q |-> (rom_sel_n && ram_sel_n));

    a_r9_dir_enabled: assert property (@(posedge clk) disable iff (rst)
        buf_dir |-> !buf_oe_n);
endmodule

bind bus_cycle_decoder bus_cycle_decoder_chk #(.ADDR_W(ADDR_W), .CT_N(bsd_pkg::CT_N)) u_chk (
    .clk(clk), .rst(rst), .alatch(alatch), .ad(ad), .lat_addr(lat_addr),
    .boot_q(boot_q), .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n),
    .buf_dir(buf_dir), .buf_oe_n(buf_oe_n), .cycle_type(cycle_type),
    .illegal_status(illegal_status)
);

// File: tb/bus_cycle_decoder_test.sv
module bus_cycle_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alatch = 1'b0;
    logic        rd_n = 1'b1;
    logic        we_n = 1'b1;
    logic [3:0]  bstat = 4'b0000;
    logic [15:0] ad = 16'h0000;
    logic        boot_sel = 1'b0;
    logic [15:0] lat_addr;
    logic        rom_sel_n, ram_sel_n, buf_dir, buf_oe_n, illegal_status;
    logic [8:0]  cycle_type;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    bus_cycle_decoder uut (
        .clk(clk), .rst(rst), .alatch(alatch), .rd_n(rd_n), .we_n(we_n),
        .bstat(bstat), .ad(ad), .boot_sel(boot_sel), .lat_addr(lat_addr),
        .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n), .buf_dir(buf_dir),
        .buf_oe_n(buf_oe_n), .cycle_type(cycle_type),
        .illegal_status(illegal_status)
    );

    function automatic logic [8:0] exp_type(logic [3:0] s);
        case (s)
            4'b1010: return 9'd1 << 0;
            4'b1101: return 9'd1 << 1;
            4'b0101: return 9'd1 << 2;
            4'b1001: return 9'd1 << 3;
            4'b1100: return 9'd1 << 4;
            4'b0110: return 9'd1 << 5;
            4'b0011: return 9'd1 << 6;
            4'b0010: return 9'd1 << 7;
            4'b1110: return 9'd1 << 8;
            default: return 9'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    // kind: 0 read, 1 write, 2 no strobe
    task automatic do_cycle(input logic [15:0] a, input logic [3:0] s, input logic p, input int kind);
        logic [8:0] et;
        logic       erom, eram;
        et   = exp_type(s);
        erom = (kind != 2) && p && (a < 16'h8000);
        eram = (kind != 2) && p && (a >= 16'h8000);
        @(negedge clk);
        alatch = 1'b1; ad = a; bstat = s; boot_sel = p; rd_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        alatch = 1'b0;
        @(posedge clk); #1;
        chk("R2 capture", lat_addr, a);
        chk("R3 type", cycle_type, et);
        chk("R4 illegal", illegal_status, (et == 9'd0));
        chk("R8 oe open", buf_oe_n, 0);
        chk("R9 dir addr phase", buf_dir, 0);
        @(negedge clk);
        ad = ~a; bstat = ~s; boot_sel = ~p;
        if (kind == 0) rd_n = 1'b0;
        if (kind == 1) we_n = 1'b0;
        #1;
        chk("R5 rom sel", rom_sel_n, !erom);
        chk("R6 ram sel", ram_sel_n, !eram);
        chk("R9 dir", buf_dir, (kind == 0));
        @(posedge clk); #1;
        chk("R2 hold", lat_addr, a);
        chk("R3 hold", cycle_type, et);
        @(negedge clk);
        rd_n = 1'b1; we_n = 1'b1;
        #1;
        chk("R7 idle sel", {rom_sel_n, ram_sel_n}, 2'b11);
        @(posedge clk); #1;
        chk("R8 oe after strobe", buf_oe_n, (kind != 2));
    endtask

    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0101));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 addr", lat_addr, 0);
        chk("R1 type", cycle_type, 0);
        chk("R1 illegal", illegal_status, 0);
        chk("R1 sels", {rom_sel_n, ram_sel_n}, 2'b11);
        chk("R1 oe", buf_oe_n, 1);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 after release", {lat_addr, cycle_type, illegal_status}, 0);

        // directed boot sequence
        do_cycle(16'h0000, 4'b1010, 1'b1, 2);
        do_cycle(16'h0000, 4'b1010, 1'b1, 2);
        do_cycle(16'h0000, 4'b1010, 1'b1, 2);
        do_cycle(16'h0000, 4'b1101, 1'b1, 2);
        do_cycle(16'h0000, 4'b0101, 1'b1, 0);
        do_cycle(16'h0000, 4'b1001, 1'b1, 2);
        do_cycle(16'h0002, 4'b0101, 1'b1, 0);
        do_cycle(16'h0000, 4'b1100, 1'b1, 2);
        do_cycle(16'h809E, 4'b0110, 1'b1, 1);
        do_cycle(16'h809C, 4'b0110, 1'b1, 1);
        do_cycle(16'h809A, 4'b0110, 1'b1, 1);
        do_cycle(16'h0008, 4'b0011, 1'b1, 0);
        do_cycle(16'h000A, 4'b0010, 1'b1, 0);
        do_cycle(16'h000C, 4'b1110, 1'b1, 2);

        // R4 every unknown code
        do_cycle(16'h1234, 4'b0000, 1'b1, 0);
        do_cycle(16'h1234, 4'b0001, 1'b1, 0);
        do_cycle(16'h1234, 4'b0100, 1'b1, 0);
        do_cycle(16'h1234, 4'b0111, 1'b1, 0);
        do_cycle(16'h1234, 4'b1000, 1'b1, 0);
        do_cycle(16'h1234, 4'b1011, 1'b1, 0);
        do_cycle(16'h1234, 4'b1111, 1'b1, 0);

        // R5 R6 R7 boundaries
        do_cycle(16'h7FFF, 4'b0011, 1'b1, 0);
        do_cycle(16'h8000, 4'b0110, 1'b1, 1);
        do_cycle(16'hFFFF, 4'b0110, 1'b1, 0);
        do_cycle(16'h7FFF, 4'b0011, 1'b0, 0);
        do_cycle(16'h8000, 4'b0110, 1'b0, 1);

        // random mix
        for (int i = 0; i < 300; i++) begin
            do_cycle(16'($urandom), 4'($urandom), 1'($urandom), int'($urandom_range(0, 2)));
        end

        summary();
        $finish;
    end
endmodule